// File: doc/BRIEF.md
# Operand Effective Address Walker

This block turns an instruction's addressing fields into a 15-bit operand address for a 16-bit word-addressed processor. The processor has a one-word (short) and a two-word (long) instruction format. The three index registers are not flip-flops: they live in memory words 1, 2 and 3. Indexing therefore costs a memory read. A long instruction may also ask for one level of indirection, which costs one more read.

The fetch stage presents the first instruction word, the second word for long instructions, and the address of the word after the instruction, together with a one-cycle start strobe. The walker then issues zero, one or two reads on its single read port and pulses a done strobe with the final address.

The read port works as follows. The request is held until a grant is returned. The data comes back later, marked by a valid pulse, and only one read is outstanding at a time.

Top module: `ea_gen`

## Requirements
- R1: Field positions in the first word: bit 10 is the long-format flag, bits 9:8 are the index selector, bit 7 is the indirect flag in long format, and bits 7:0 are a signed two's-complement displacement in short format. Bits 15:11 and, in long format, bits 6:0 do not affect the result.
- R2: Short format with selector 0 adds the sign-extended displacement to the next-word address input. No read is issued, and the done strobe is high in the cycle after start is accepted.
- R3: Short format with selector t of 1, 2 or 3 issues one read at address t and returns that word plus the sign-extended displacement. Selector 3 picks word 3.
- R4: Long format with the indirect flag clear and selector 0 returns bits 14:0 of the second word. No read is issued, and done follows start by one cycle.
- R5: Long format with the indirect flag clear and selector t ≠ 0 issues one read at address t and returns the second word plus the fetched index. Selector 3 picks word 3.
- R6: Long format with the indirect flag set and selector 0 issues one read at the second word's address and returns the fetched word.
- R7: Long format with the indirect flag set and selector t ≠ 0 makes two reads in order. The first is at address t. The second is at the second word plus the fetched index. The result is the word returned by the second read.
- R8: All sums wrap modulo 2^15. Bit 15 of every fetched word and of the second instruction word is ignored.
- R9: A request holds its address stable until granted, and no new request is raised while a read is outstanding. Done is a single-cycle pulse, high in the cycle after the last read data is accepted.
- R10: A start pulse while the walker is busy is ignored. The result of the current operation is unchanged.
- R11: After reset the walker is idle: busy, request and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation (taken only when idle) |
| ins_w0 | input | 16 | First instruction word |
| ins_w1 | input | 16 | Second instruction word (long format) |
| next_addr | input | 15 | Address of the word following the instruction |
| busy | output | 1 | Computation in progress |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 15 | Read address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| ea_done | output | 1 | One-cycle strobe: ea_addr holds the result |
| ea_addr | output | 15 | Effective address |

## Verification
The two direct modes (R2, R4) must show done exactly one cycle after start. Every other mode must show done exactly one cycle after the read-data pulse of its last read, however long the grant and data stalls last. The bench memory model stalls grants and data by a random number of cycles. It records the cycle in which each data pulse is driven and expects the done strobe at the very next sampling point, not before and not after. At each sampling point between start and done, the bench checks that done is low. It also compares every granted address, in order, with the read sequence the requirements predict for that mode.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XREQ,
      ST_XWAIT,
      ST_IREQ,
      ST_IWAIT,
      ST_DONE
   } walk_state_t;
endpackage

// File: rtl/ea_field_dec.sv
module ea_field_dec #(
   parameter int DW        = 16,
   parameter int AW        = 15,
   parameter int DISP_W    = 8,
   parameter bit SIGN_DISP = 1'b1
) (
   input  logic [DW-1:0] word0,
   output logic          is_long,
   output logic [1:0]    sel,
   output logic          indirect,
   output logic [AW-1:0] disp_ext
);
   localparam int FMT_BIT = DW - 6;
   localparam int SEL_HI  = DW - 7;
   localparam int IND_BIT = DW - 9;

   if (DISP_W > AW) begin : g_bad_disp
      $error("ea_field_dec: DISP_W must not exceed AW");
   end
   if (DW < 12) begin : g_bad_dw
      $error("ea_field_dec: DW too small for the field layout");
   end

   assign is_long  = word0[FMT_BIT];
   assign sel      = word0[SEL_HI -: 2];
   assign indirect = word0[IND_BIT];

   if (SIGN_DISP) begin : g_signed
      assign disp_ext = {{(AW-DISP_W){word0[DISP_W-1]}}, word0[DISP_W-1:0]};
   end else begin : g_unsigned
      assign disp_ext = {{(AW-DISP_W){1'b0}}, word0[DISP_W-1:0]};
   end

   logic unused_op;
   assign unused_op = ^{word0[DW-1:FMT_BIT+1]};
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
   parameter int AW = 15
) (
   input  logic [AW-1:0] op_a,
   input  logic [AW-1:0] op_b,
   output logic [AW-1:0] sum
);
   if (AW < 2) begin : g_bad_aw
      $error("ea_adder: AW too small");
   end
   assign sum = op_a + op_b;
endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import ea_pkg::*;
#(
   parameter int AW      = 15,
   parameter int XR_BASE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_long,
   input  logic [1:0]    sel,
   input  logic          indirect,
   input  logic [AW-1:0] disp_ext,
   input  logic [AW-1:0] word1_addr,
   input  logic [AW-1:0] base_addr,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   input  logic [AW-1:0] rdata_addr,
   input  logic [AW-1:0] sum,
   output logic [AW-1:0] add_a,
   output logic [AW-1:0] add_b,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          busy,
   output logic          ea_done,
   output logic [AW-1:0] ea_addr
);
   localparam logic [AW-1:0] XR_OFS = AW'(XR_BASE);

   walk_state_t   state_q;
   logic [AW-1:0] off_q;
   logic [AW-1:0] acc_q;
   logic          chain_q;
   logic [AW-1:0] off_now;

   assign off_now = is_long ? word1_addr : disp_ext;
   assign add_a   = (state_q == ST_IDLE) ? base_addr : rdata_addr;
   assign add_b   = (state_q == ST_IDLE) ? off_now   : off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         off_q   <= '0;
         acc_q   <= '0;
         chain_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               off_q   <= off_now;
               chain_q <= is_long & indirect;
               if (sel != 2'd0) begin
                  acc_q   <= XR_OFS + AW'(sel);
                  state_q <= ST_XREQ;
               end else if (is_long && indirect) begin
                  acc_q   <= word1_addr;
                  state_q <= ST_IREQ;
               end else begin
                  acc_q   <= is_long ? word1_addr : sum;
                  state_q <= ST_DONE;
               end
            end
            ST_XREQ:  if (mem_gnt) state_q <= ST_XWAIT;
            ST_XWAIT: if (mem_rvalid) begin
               acc_q   <= sum;
               state_q <= chain_q ? ST_IREQ : ST_DONE;
            end
            ST_IREQ:  if (mem_gnt) state_q <= ST_IWAIT;
            ST_IWAIT: if (mem_rvalid) begin
               acc_q   <= rdata_addr;
               state_q <= ST_DONE;
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req  = (state_q == ST_XREQ) || (state_q == ST_IREQ);
   assign mem_addr = acc_q;
   assign busy     = (state_q != ST_IDLE);
   assign ea_done  = (state_q == ST_DONE);
   assign ea_addr  = acc_q;

   // R9: request held with a stable address until granted
   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
   // R9: done is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ea_done |=> !ea_done);
   // R9: no request while the result is presented
   a_r9_req_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ea_done);
   // R10: busy only ever rises from an accepted start
   a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R2 / R4: direct modes finish one cycle after start
   a_r2_direct_fast: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && sel == 2'd0 && !(is_long && indirect) |=> ea_done);
   // R3 / R5: indexed modes first read an index word
   a_r3_index_first: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && sel != 2'd0 |=> mem_req && mem_addr == XR_OFS + AW'($past(sel)));
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
   parameter int DW        = 16,
   parameter int AW        = 15,
   parameter int DISP_W    = 8,
   parameter int XR_BASE   = 0,
   parameter bit SIGN_DISP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] ins_w0,
   input  logic [DW-1:0] ins_w1,
   input  logic [AW-1:0] next_addr,
   output logic          busy,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          ea_done,
   output logic [AW-1:0] ea_addr
);
   if (AW >= DW) begin : g_bad_aw
      $error("ea_gen: AW must be narrower than DW");
   end
   if (XR_BASE + 3 >= (1 << AW)) begin : g_bad_base
      $error("ea_gen: index words must fit in the address space");
   end

   logic          is_long, indirect;
   logic [1:0]    sel;
   logic [AW-1:0] disp_ext, add_a, add_b, sum;

   ea_field_dec #(.DW(DW), .AW(AW), .DISP_W(DISP_W), .SIGN_DISP(SIGN_DISP)) u_dec (
      .word0(ins_w0), .is_long(is_long), .sel(sel),
      .indirect(indirect), .disp_ext(disp_ext)
   );

   ea_adder #(.AW(AW)) u_add (.op_a(add_a), .op_b(add_b), .sum(sum));

   ea_seq #(.AW(AW), .XR_BASE(XR_BASE)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .is_long(is_long), .sel(sel), .indirect(indirect), .disp_ext(disp_ext),
      .word1_addr(ins_w1[AW-1:0]), .base_addr(next_addr),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .rdata_addr(mem_rdata[AW-1:0]),
      .sum(sum), .add_a(add_a), .add_b(add_b),
      .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy),
      .ea_done(ea_done), .ea_addr(ea_addr)
   );

   logic unused_hi;
   assign unused_hi = ^{ins_w1[DW-1:AW], mem_rdata[DW-1:AW]};
endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] ins_w0 = '0, ins_w1 = '0;
   logic [14:0] next_addr = '0;
   logic        busy, mem_req, ea_done;
   logic [14:0] mem_addr, ea_addr;
   logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = '0;

   int n_vec = 0, n_bad = 0, cyc = 0;
   bit finished = 0;
   logic [15:0] xr1 = 16'h0100, xr2 = 16'h7FF0, xr3 = 16'h8005;
   int exp_q[$];
   int exp_ea;
   string exp_tag;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ea_gen uut (.*);

   function automatic logic [15:0] mem_word(input int a);
      int h;
      if (a == 1) return xr1;
      if (a == 2) return xr2;
      if (a == 3) return xr3;
      h = (a * 40503) ^ 46017;
      return h[15:0];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // expected read sequence and result from the requirements (R1..R8)
   task automatic predict(input logic [15:0] w0, input logic [15:0] w1, input logic [14:0] na);
      int lng, tg, ind, d, a;
      lng = w0[10]; tg = w0[9:8]; ind = w0[7];
      d = w0[7] ? int'(w0[7:0]) - 256 : int'(w0[7:0]);
      exp_q.delete();
      if (!lng) begin
         exp_tag = (tg == 0) ? "R2" : "R3";
         if (tg == 0) a = na;
         else begin exp_q.push_back(tg); a = mem_word(tg) & 32767; end
         exp_ea = (a + d + 32768) & 32767;
      end else begin
         a = w1 & 32767;
         if (tg != 0) begin
            exp_q.push_back(tg);
            a = (a + (mem_word(tg) & 32767)) & 32767;
         end
         if (ind) begin
            exp_tag = (tg == 0) ? "R6" : "R7";
            exp_q.push_back(a);
            exp_ea = mem_word(a) & 32767;
         end else begin
            exp_tag = (tg == 0) ? "R4" : "R5";
            exp_ea = a;
         end
      end
   endtask

   task automatic run_txn(input logic [15:0] w0, input logic [15:0] w1,
                          input logic [14:0] na, input bit poke);
      int due, it, lat, e;
      bit outst, fin;
      @(negedge clk);
      ins_w0 = w0; ins_w1 = w1; next_addr = na; start = 1'b1;
      predict(w0, w1, na);
      due = (exp_q.size() == 0) ? cyc + 1 : -1;
      it = 0; lat = 0; outst = 0; fin = 0;
      while (!fin) begin
         @(negedge clk);
         it++;
         start = 1'b0;
         if (ea_done) begin
            chk(cyc == due, "R9 done timing", cyc, due);
            chk(ea_addr == exp_ea[14:0], exp_tag, int'(ea_addr), exp_ea);
            chk(exp_q.size() == 0, "R9 read count", exp_q.size(), 0);
            mem_gnt = 1'b0; mem_rvalid = 1'b0;
            fin = 1;
         end else begin
            if (due == cyc) chk(0, "R9 done missing", 0, 1);
            if (it > 60) begin chk(0, "R9 hang", it, 0); fin = 1; end
            mem_rvalid = 1'b0;
            if (mem_gnt) mem_gnt = 1'b0;
            else if (outst) begin
               if (mem_req) chk(0, "R9 request while outstanding", 1, 0);
               if (lat == 0) begin
                  mem_rvalid = 1'b1;
                  mem_rdata = mem_word(int'(mem_addr));
                  outst = 0;
                  if (exp_q.size() == 0) due = cyc + 1;
               end else lat--;
            end else if (mem_req && $urandom_range(0, 2) != 0) begin
               mem_gnt = 1'b1;
               if (exp_q.size() == 0) chk(0, {exp_tag, " extra read"}, int'(mem_addr), -1);
               else begin
                  e = exp_q.pop_front();
                  chk(int'(mem_addr) == e, {exp_tag, " read address"}, int'(mem_addr), e);
               end
               outst = 1;
               lat = $urandom_range(0, 2);
            end
            if (poke && it == 2 && busy) begin
               start = 1'b1; ins_w0 = ~w0; ins_w1 = ~w1; next_addr = ~na;
            end
         end
      end
      @(negedge clk);
      chk(!ea_done, "R9 single pulse", ea_done, 0);
      chk(!busy, "R10 idle after done", busy, 0);
   endtask

   function automatic logic [15:0] sw(input logic [1:0] t, input logic [7:0] d);
      return {5'b01101, 1'b0, t, d};
   endfunction
   function automatic logic [15:0] lw(input logic [1:0] t, input logic i);
      return {5'b10011, 1'b1, t, i, 7'h5A};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !ea_done, "R11 reset state", {busy, mem_req, ea_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req && !ea_done, "R11 idle after reset", {busy, mem_req, ea_done}, 0);
      // R2 / R1: relative short, positive, negative, wrap below zero
      run_txn(sw(2'd0, 8'h7F), 16'hFFFF, 15'd1000, 0);
      run_txn(sw(2'd0, 8'h80), 16'h0000, 15'd1000, 0);
      run_txn(sw(2'd0, 8'hFB), 16'h0000, 15'd2, 0);
      run_txn({5'b11111, 1'b0, 2'd0, 8'h01}, 16'h1234, 15'h7FFF, 0);
      // R3: short indexed, all selectors; R8 bit 15 of xr3 ignored
      run_txn(sw(2'd1, 8'hFF), 16'h0, 15'd5, 0);
      run_txn(sw(2'd2, 8'h20), 16'h0, 15'd5, 0);
      run_txn(sw(2'd3, 8'h03), 16'h0, 15'd5, 0);
      // R4, R5 with selector 3; R8 wrap of sum and w1 bit 15
      run_txn(lw(2'd0, 1'b0), 16'hC123, 15'd9, 0);
      run_txn(lw(2'd3, 1'b0), 16'h0040, 15'd9, 0);
      run_txn(lw(2'd2, 1'b0), 16'h0020, 15'd9, 0);
      // R6, R7
      run_txn(lw(2'd0, 1'b1), 16'h0444, 15'd9, 0);
      run_txn(lw(2'd2, 1'b1), 16'h0100, 15'd9, 0);
      run_txn(lw(2'd1, 1'b1), 16'h8300, 15'd9, 0);
      // R10: start pulses while busy
      run_txn(lw(2'd3, 1'b1), 16'h0007, 15'd9, 1);
      run_txn(sw(2'd1, 8'h10), 16'h0, 15'd77, 1);
      xr1 = 16'hFFFF; xr2 = 16'h0003; xr3 = 16'h4000;
      for (int k = 0; k < 80; k++) begin
         logic [15:0] w0r, w1r;
         w0r = 16'($urandom); w1r = 16'($urandom);
         run_txn(w0r, w1r, 15'($urandom), (k % 7) == 0);
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule